// File: doc/BRIEF.md
# Packed Floating-Point Control and Status Register

This block holds the control and status word of a packed floating-point unit. It keeps six sticky exception flags, one mask bit per exception type, a two-bit rounding mode and a flush-to-zero enable. The rounding mode and the flush-to-zero enable go straight out to the arithmetic datapath. Software writes the word through a load port and reads it back through a read port that always shows the current value.

Each packed operation that completes reports six exception bits for each of its lanes on a valid strobe. The block ORs the lanes into one set of bits and adds those bits to the sticky flags. If any of the merged exceptions is unmasked, the block raises a one-cycle trap request together with the causing bits. Clearing a mask while its flag is already set raises no trap. The trap waits until a later operation raises that exception type again.

A load that carries a non-zero value in any reserved position is refused. A refused load leaves the control fields unchanged and raises a one-cycle fault pulse. The reserved positions are bits 31 to 16 and bit 6.

Top module: `vfp_ctrl_status`

## Requirements
- R1: After reset, rd_data reads 0x00001F80: all flags clear, all six masks set, rounding mode 00 and flush-to-zero off. round_mode is 00 and flush_zero is 0.
- R2: A load with ld_valid high and bits 31..16 and bit 6 all zero is accepted. From the next cycle on, rd_data equals the loaded word.
- R3: A load with any of bits 31..16 or bit 6 set is refused. The mask, rounding and flush-to-zero fields stay unchanged, and ld_fault is high for exactly the one cycle after the load.
- R4: round_mode shows bits 14..13 of the register (00 nearest even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero). flush_zero shows bit 15.
- R5: Exception bit order is invalid (0), denormal (1), divide by zero (2), overflow (3), underflow (4) and precision (5). Lane k occupies op_exc[6k+5:6k]. When op_valid is high, the OR of all lanes is ORed into flag bits 5..0, which stay set until a load clears them.
- R6: The mask for flag i sits at bit i+7, and a set mask bit masks that exception. In the cycle after op_valid, trap_req is 1 exactly when some merged bit has its mask clear. trap_cause then holds those unmasked merged bits and is zero otherwise. The masks used are the ones held before any load in the same cycle.
- R7: A load that clears a mask while the matching flag is set, or that sets a flag while its mask is clear, raises no trap request.
- R8: When an accepted load and an operation report arrive in the same cycle, the flags take the loaded value. When a refused load and a report arrive together, the report still merges into the flags.
- R9: Exceptions whose masks are set still set their flags but raise no trap request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | 1 | Register load strobe |
| ld_data | input | 32 | Word to load |
| ld_fault | output | 1 | One-cycle pulse after a refused load |
| rd_data | output | 32 | Current register value, reserved bits zero |
| op_valid | input | 1 | Operation exception report strobe |
| op_exc | input | LANES*6 | Per-lane exception bits, lane k at [6k+5:6k] |
| trap_req | output | 1 | One-cycle trap request for an unmasked exception |
| trap_cause | output | 6 | Unmasked merged exception bits behind trap_req |
| round_mode | output | 2 | Rounding mode to the datapath |
| flush_zero | output | 1 | Flush-to-zero enable to the datapath |

## Verification
The hardest case to reach is a flag that is already pending while its mask has just been cleared. No trap may follow at that point, and the trap must come only on the next report of that same exception. Directed steps build this case in order: a load sets flags with the masks clear, the bench watches for no trap, and a later single-lane report then raises the trap. Same-cycle collisions are also directed. These cover a load together with a report, and a refused load together with a report, which checks that the old masks decide the trap. A seeded random run mixes legal loads, illegal loads and sparse lane reports. Every output is compared against a bench model after each cycle.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int EXC_W       = 6;
  localparam int REG_W       = 32;
  localparam int FLAG_LSB    = 0;
  localparam int RSV_LOW_BIT = 6;
  localparam int MASK_LSB    = 7;
  localparam int RND_LSB     = 13;
  localparam int RND_W       = 2;
  localparam int FZ_BIT      = 15;
  localparam int USED_W      = 16;

  typedef enum logic [RND_W-1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  typedef struct packed {
    logic             fz;
    rnd_e             rnd;
    logic [EXC_W-1:0] mask;
    logic [EXC_W-1:0] flags;
  } csr_t;

  localparam csr_t CSR_RESET = '{fz: 1'b0, rnd: RND_NEAR, mask: '1, flags: '0};

  function automatic logic [REG_W-1:0] csr_pack(input csr_t c);
    logic [REG_W-1:0] v;
    v = '0;
    v[FLAG_LSB +: EXC_W] = c.flags;
    v[MASK_LSB +: EXC_W] = c.mask;
    v[RND_LSB +: RND_W]  = c.rnd;
    v[FZ_BIT]            = c.fz;
    return v;
  endfunction

  function automatic csr_t csr_unpack(input logic [REG_W-1:0] v);
    csr_t c;
    c.flags = v[FLAG_LSB +: EXC_W];
    c.mask  = v[MASK_LSB +: EXC_W];
    c.rnd   = rnd_e'(v[RND_LSB +: RND_W]);
    c.fz    = v[FZ_BIT];
    return c;
  endfunction

endpackage

// File: rtl/fpcsr_rst_sync.sv
module fpcsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/fpcsr_lane_or.sv
module fpcsr_lane_or #(
  parameter int LANES = 4,
  parameter int W     = 6
) (
  input  logic [LANES*W-1:0] lanes_i,
  output logic [W-1:0]       merged_o
);
  logic [LANES:0][W-1:0] acc;

  assign acc[0] = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign acc[g+1] = acc[g] | lanes_i[g*W +: W];
  end

  assign merged_o = acc[LANES];
endmodule

// File: rtl/fpcsr_load_check.sv
module fpcsr_load_check
  import fpcsr_pkg::*;
(
  input  logic             ld_valid,
  input  logic [REG_W-1:0] ld_data,
  output logic             ld_accept,
  output logic             ld_reject,
  output csr_t             ld_csr
);
  logic rsv_hit;

  always_comb begin
    rsv_hit   = (|ld_data[REG_W-1:USED_W]) | ld_data[RSV_LOW_BIT];
    ld_accept = ld_valid & ~rsv_hit;
    ld_reject = ld_valid &  rsv_hit;
    ld_csr    = csr_unpack(ld_data);
  end
endmodule

// File: rtl/vfp_ctrl_status.sv
module vfp_ctrl_status
  import fpcsr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic [REG_W-1:0]       ld_data,
  output logic                   ld_fault,
  output logic [REG_W-1:0]       rd_data,
  input  logic                   op_valid,
  input  logic [LANES*EXC_W-1:0] op_exc,
  output logic                   trap_req,
  output logic [EXC_W-1:0]       trap_cause,
  output logic [RND_W-1:0]       round_mode,
  output logic                   flush_zero
);

  logic             srst_n;
  logic             ld_accept;
  logic             ld_reject;
  csr_t             ld_csr;
  logic [EXC_W-1:0] merged;

  csr_t             csr_q, csr_d;
  logic             csr_en;
  logic             fault_q, fault_d;
  logic             trap_q, trap_d;
  logic [EXC_W-1:0] cause_q, cause_d;
  logic [EXC_W-1:0] unmasked;

  fpcsr_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fpcsr_load_check u_load_check (
    .ld_valid  (ld_valid),
    .ld_data   (ld_data),
    .ld_accept (ld_accept),
    .ld_reject (ld_reject),
    .ld_csr    (ld_csr)
  );

  fpcsr_lane_or #(.LANES(LANES), .W(EXC_W)) u_lane_or (
    .lanes_i  (op_exc),
    .merged_o (merged)
  );

  // next-state: an accepted load wins over a report for the flag bits
  always_comb begin
    csr_d    = csr_q;
    csr_en   = ld_accept | op_valid;
    unmasked = merged & ~csr_q.mask;
    if (ld_accept) begin
      csr_d = ld_csr;
    end else if (op_valid) begin
      csr_d.flags = csr_q.flags | merged;
    end
    trap_d  = op_valid & (|unmasked);
    cause_d = op_valid ? unmasked : '0;
    fault_d = ld_reject;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      csr_q <= CSR_RESET;
    end else if (csr_en) begin
      csr_q <= csr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      fault_q <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      fault_q <= fault_d;
      trap_q  <= trap_d;
      cause_q <= cause_d;
    end
  end

  assign rd_data    = csr_pack(csr_q);
  assign ld_fault   = fault_q;
  assign trap_req   = trap_q;
  assign trap_cause = cause_q;
  assign round_mode = csr_q.rnd;
  assign flush_zero = csr_q.fz;

  // accepted load appears on the read port one cycle later
  assert_load_visible_R2: assert property (@(posedge clk) disable iff (!srst_n)
    ld_accept |=> rd_data == $past(ld_data));

  // refused load keeps control fields and pulses the fault
  assert_reject_holds_R3: assert property (@(posedge clk) disable iff (!srst_n)
    ld_reject |=> ($stable(rd_data[15:7]) && ld_fault));

  assert_fault_cause_R3: assert property (@(posedge clk) disable iff (!srst_n)
    ld_fault |-> $past(ld_valid));

  // flags only grow unless a load was accepted
  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !ld_accept |=> ((rd_data[5:0] & $past(rd_data[5:0])) == $past(rd_data[5:0])));

  // a trap needs a report and only carries bits whose mask was clear
  assert_trap_unmasked_R6: assert property (@(posedge clk) disable iff (!srst_n)
    trap_req |-> ($past(op_valid) && (trap_cause != '0) &&
                  ((trap_cause & $past(rd_data[12:7])) == '0)));

  // no report, no trap (covers unmasking a pending flag)
  assert_no_trap_without_op_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !op_valid |=> !trap_req);

endmodule

// File: tb/vfp_ctrl_status_tb.sv
`timescale 1ns/1ps
module vfp_ctrl_status_tb;

  localparam int LANES = 4;
  localparam int EW    = 6;

  logic              clk;
  logic              rst_n;
  logic              ld_valid;
  logic [31:0]       ld_data;
  logic              ld_fault;
  logic [31:0]       rd_data;
  logic              op_valid;
  logic [LANES*EW-1:0] op_exc;
  logic              trap_req;
  logic [EW-1:0]     trap_cause;
  logic [1:0]        round_mode;
  logic              flush_zero;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] exp_csr;

  vfp_ctrl_status #(.LANES(LANES)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data),
    .ld_fault   (ld_fault),
    .rd_data    (rd_data),
    .op_valid   (op_valid),
    .op_exc     (op_exc),
    .trap_req   (trap_req),
    .trap_cause (trap_cause),
    .round_mode (round_mode),
    .flush_zero (flush_zero)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [EW-1:0] lane_merge(input logic [LANES*EW-1:0] e);
    logic [EW-1:0] m;
    m = '0;
    for (int k = 0; k < LANES; k++) m = m | e[k*EW +: EW];
    return m;
  endfunction

  function automatic bit rsv_set(input logic [31:0] d);
    return (d[31:16] != 16'h0) || d[6];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [31:0] ld, input logic ov,
                      input logic [LANES*EW-1:0] oe, input string tag);
    logic [EW-1:0] m;
    logic [EW-1:0] e_cause;
    logic          e_trap;
    logic          e_fault;
    ld_valid = lv;
    ld_data  = ld;
    op_valid = ov;
    op_exc   = oe;
    m        = lane_merge(oe);
    e_cause  = ov ? (m & ~exp_csr[12:7]) : '0;
    e_trap   = |e_cause;
    e_fault  = lv && rsv_set(ld);
    if (lv && !rsv_set(ld)) exp_csr = ld;
    else if (ov)            exp_csr[5:0] = exp_csr[5:0] | m;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    op_valid = 1'b0;
    check(tag, "rd_data",    rd_data, exp_csr);
    check(tag, "ld_fault",   {31'd0, ld_fault}, {31'd0, e_fault});
    check(tag, "trap_req",   {31'd0, trap_req}, {31'd0, e_trap});
    check(tag, "trap_cause", {26'd0, trap_cause}, {26'd0, e_cause});
    check("R4", "round_mode", {30'd0, round_mode}, {30'd0, exp_csr[14:13]});
    check("R4", "flush_zero", {31'd0, flush_zero}, {31'd0, exp_csr[15]});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] d;
    logic [LANES*EW-1:0] e;
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    ld_valid = 1'b0;
    ld_data  = '0;
    op_valid = 1'b0;
    op_exc   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    exp_csr = 32'h0000_1F80;
    check("R1", "rd_data",    rd_data, 32'h0000_1F80);
    check("R1", "round_mode", {30'd0, round_mode}, 32'd0);
    check("R1", "flush_zero", {31'd0, flush_zero}, 32'd0);
    check("R1", "trap_req",   {31'd0, trap_req}, 32'd0);
    check("R1", "ld_fault",   {31'd0, ld_fault}, 32'd0);

    // R2 legal load, toward-zero rounding, flush on, flags set
    step(1'b1, 32'h0000_E03F, 1'b0, '0, "R2");
    // R3 refused loads: bit 6 alone, then a high reserved bit
    step(1'b1, 32'h0000_0040, 1'b0, '0, "R3");
    step(1'b1, 32'h8000_1F80, 1'b0, '0, "R3");
    step(1'b0, 32'h0, 1'b0, '0, "R3");
    // R4 rounding toward minus infinity, all masked, flags clear
    step(1'b1, 32'h0000_3F80, 1'b0, '0, "R4");
    // R9 masked exceptions: flags set, no trap
    step(1'b0, 32'h0, 1'b1, 24'h00_003F, "R9");
    // R7 unmask with pending flags: no trap
    step(1'b1, 32'h0000_003F, 1'b0, '0, "R7");
    step(1'b0, 32'h0, 1'b0, '0, "R7");
    // R6/R5 later report in lane 3 traps on divide by zero
    step(1'b0, 32'h0, 1'b1, 24'h10_0000, "R6");
    // R5 clear flags, then lane merge of overflow from lanes 1 and 2
    step(1'b1, 32'h0000_1000, 1'b0, '0, "R5");
    step(1'b0, 32'h0, 1'b1, 24'h00_8200, "R5");
    // R8 accepted load with report: load wins flags, old masks decide trap
    step(1'b1, 32'h0000_1F80, 1'b1, 24'hFF_FFFF, "R8");
    // R8 refused load with report: report merges, fault
    step(1'b1, 32'h0001_0000, 1'b1, 24'h04_0001, "R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      d = $urandom;
      if (r[1:0] != 2'b00) d = d & 32'h0000_FFBF;
      e = $urandom & $urandom & $urandom;
      step(r[2] & r[3], d, r[4], e, "R5/R6");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule